// File: doc/BRIEF.md
# Sponge and Duplex Block Padder

This block sits in front of a Keccak-style permutation core that serves four modes: hashing, keyed MAC, authenticated encryption (AEAD) and pseudo-random generation (PRNG). It takes a 16-bit byte stream split into segments and packs each segment into rate-sized blocks. It then adds the padding or frame bits that the selected mode and segment kind call for. The core downstream receives one complete 1348-bit block at a time over a valid/ready handshake.

Sponge modes (hash, MAC) produce 1088-bit blocks in the low part of the output and use byte-wise pad10*1. Duplex modes (AEAD, PRNG) produce 1344 data bits plus four frame bits. In MAC mode the key and IV are packed into one fixed-layout block. In PRNG mode each request carries a seed of up to 32 bytes, which may be empty.

Back-pressure works as follows. `in_ready` is high only while the block is collecting bytes. From the moment a block is complete until the downstream handshake, and for the one cycle spent adding padding, `in_ready` is low and no input byte is taken. Once `out_valid` is high it stays high, with `out_block` unchanged, until `out_ready` is seen at a clock edge.

Top module: `spdx_padder`

## Requirements
- R1: Input encodings and block layout.
  - `mode` encodings: 0 = hash, 1 = MAC, 2 = AEAD, 3 = PRNG.
  - `kind` encodings: 0 = key/IV, 1 = associated data, 2 = message, 3 = seed.
  - Within a word, `in_data[15:8]` is the earlier byte. Every word except the last of a segment carries 2 bytes. On the last word, `in_bytes` gives 0, 1 or 2 valid bytes.
  - Sponge output: block byte i sits at `out_block[1087-8i -: 8]` and bits 1347..1088 are zero. A full non-final sponge block is emitted with no padding.
- R2: Sponge padding: byte 0x01 is XORed at the position right after the last data byte, byte 0x80 is XORed at byte 135, and all other bytes are zero.
- R3: When a sponge segment leaves exactly 135 bytes in its final block, byte 135 holds 0x81.
- R4: When a sponge segment ends exactly at a block boundary, an additional block follows that holds only 0x01 at byte 0 and 0x80 at byte 135.
- R5: A zero-length segment (`in_last` with `in_bytes`=0 on its only word) yields exactly one fully padded block.
- R6: MAC mode with kind key/IV takes 16 key bytes then 16 IV bytes and emits one sponge block laid out as follows:
  - byte 0 = 0x1E;
  - bytes 1..16 = key;
  - byte 17 = 0x01;
  - byte 30 = 0x01;
  - bytes 32..47 = IV;
  - byte 48 = 0x01;
  - byte 135 = 0x80;
  - all other bytes zero.
- R7: AEAD duplex blocks and frame nibble.
  - Data byte i is at `out_block[1347-8i -: 8]` (168 bytes) and the frame nibble is at `out_block[3:0]`. Data bytes past the end of the segment are zero.
  - Frame nibble values:
    - associated-data block, not last: 0;
    - associated-data block, last: 1;
    - message block, not last: 3;
    - message block, last: 1.
- R8: PRNG block layout.
  - Bytes 0..31 hold the seed, zero-filled, and seed bytes past 32 are dropped.
  - Byte 32 is 0x06 if `in_seq_end` was high on the last word, else 0x05.
  - Bits 7..0 are 0x08, which means frame nibble 8.
  - An empty seed still yields one such block.
- R9: Handshake rules.
  - `in_ready` is low whenever `out_valid` is high.
  - While `out_valid` is high and `out_ready` is low, `out_block` and `out_valid` hold.
  - A handshake drops `out_valid` in the next cycle.
  - Every block is delivered in order with no byte lost.
- R10: After reset, `out_valid` is 0 and `in_ready` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Input word valid |
| in_ready | output | 1 | Input word accepted at this edge when high with in_valid |
| in_data | input | 16 | Two bytes, earlier byte in the upper half |
| in_bytes | input | 2 | Valid bytes in the word (2 except possibly on the last) |
| in_last | input | 1 | Word ends the segment |
| in_seq_end | input | 1 | PRNG request is the last of its sequence (sampled with in_last) |
| mode | input | 2 | Mode, sampled on the first word of a segment |
| kind | input | 2 | Segment kind, sampled on the first word of a segment |
| out_valid | output | 1 | Padded block available |
| out_ready | input | 1 | Downstream takes the block |
| out_block | output | 1348 | Padded block |

## Verification
The bench feeds sponge segments of 5, 0, 135, 136 and 300 bytes. These lengths separate a plain tail, an empty message, the merged 0x81 byte, the extra padding-only block and a multi-block run. A MAC key/IV block followed by a MAC message checks the fixed header packing against ordinary padding. AEAD associated data of 40 and 168 bytes and a 200-byte message distinguish the four frame values, including a last block that is exactly full. PRNG seeds of 32, 0 and 40 bytes with and without the sequence-end flag cover the frame byte, the empty seed and seed truncation. The later half of the run toggles `out_ready` pseudo-randomly so that hold and stall behaviour is compared against the model on every clock.

// File: rtl/spdx_pkg.sv
package spdx_pkg;
  localparam int SPG_BYTES  = 136;
  localparam int DPX_BYTES  = 168;
  localparam int SEED_BYTES = 32;
  localparam int KEY_BYTES  = 16;
  localparam int KEY_POS    = 1;
  localparam int KEY_END    = KEY_POS + KEY_BYTES;
  localparam int IV_POS     = 32;
  localparam int LEN_POS    = IV_POS - 2;
  localparam int FRM_W      = 4;
  localparam int OUT_W      = DPX_BYTES * 8 + FRM_W;
  localparam int IDX_W      = $clog2(DPX_BYTES + 1);

  localparam logic [7:0] PAD_OPEN  = 8'h01;
  localparam logic [7:0] PAD_CLOSE = 8'h80;
  localparam logic [7:0] KEY_TAG   = 8'h1E;
  localparam logic [7:0] KEY_SEP   = 8'h01;
  localparam logic [7:0] LEN_HI    = 8'h01;
  localparam logic [7:0] PRNG_MID  = 8'h05;
  localparam logic [7:0] PRNG_END  = 8'h06;

  localparam logic [FRM_W-1:0] FRM_AD_MID  = 4'h0;
  localparam logic [FRM_W-1:0] FRM_MSG_MID = 4'h3;
  localparam logic [FRM_W-1:0] FRM_END     = 4'h1;
  localparam logic [FRM_W-1:0] PRNG_TAIL   = 4'h8;

  typedef enum logic [1:0] {MD_HASH = 2'd0, MD_MAC = 2'd1, MD_AEAD = 2'd2, MD_PRNG = 2'd3} mode_e;
  typedef enum logic [1:0] {KD_KEYIV = 2'd0, KD_AD = 2'd1, KD_MSG = 2'd2, KD_SEED = 2'd3} kind_e;
  typedef enum logic [1:0] {ST_FILL = 2'd0, ST_PAD = 2'd1, ST_SEND = 2'd2} st_e;

  function automatic logic [IDX_W-1:0] cap_of(mode_e m);
    case (m)
      MD_HASH, MD_MAC: cap_of = IDX_W'(SPG_BYTES);
      MD_PRNG:         cap_of = IDX_W'(SEED_BYTES);
      default:         cap_of = IDX_W'(DPX_BYTES);
    endcase
  endfunction

  function automatic logic is_spg(mode_e m);
    is_spg = (m == MD_HASH) || (m == MD_MAC);
  endfunction
endpackage

// File: rtl/spdx_ctrl.sv
module spdx_ctrl
  import spdx_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  input  logic [1:0]       in_bytes,
  input  logic             in_last,
  input  logic             in_seq_end,
  input  logic [1:0]       mode_i,
  input  logic [1:0]       kind_i,
  output logic             in_ready,
  output logic             out_valid,
  input  logic             out_ready,
  output logic             clr,
  output logic             wr0_en,
  output logic [IDX_W-1:0] wr0_idx,
  output logic             wr1_en,
  output logic [IDX_W-1:0] wr1_idx,
  output logic             hdr_en,
  output logic             x0_en,
  output logic [IDX_W-1:0] x0_idx,
  output logic [7:0]       x0_val,
  output logic             x1_en,
  output logic [IDX_W-1:0] x1_idx,
  output logic [7:0]       x1_val,
  output logic             dpx,
  output logic [FRM_W-1:0] frm
);
  st_e              st;
  mode_e            md, cur_md;
  kind_e            kd, cur_kd;
  logic             seg_open, last_seen, pad_pend, seq_end;
  logic [IDX_W-1:0] ptr, wp, cap_cur;
  logic [IDX_W:0]   nxt_raw, nxt_c;
  logic [1:0]       nb;
  logic             acc, mac_key;

  always_comb begin
    in_ready  = (st == ST_FILL);
    out_valid = (st == ST_SEND);
    acc       = in_valid && in_ready;
    cur_md    = seg_open ? md : mode_e'(mode_i);
    cur_kd    = seg_open ? kd : kind_e'(kind_i);
    mac_key   = (cur_md == MD_MAC) && (cur_kd == KD_KEYIV);
    wp        = seg_open ? ptr : (mac_key ? IDX_W'(KEY_POS) : '0);
    nb        = (in_bytes > 2'd2) ? 2'd2 : in_bytes;
    cap_cur   = cap_of(cur_md);
    nxt_raw   = {1'b0, wp} + (IDX_W+1)'(nb);
    if (mac_key && nxt_raw == (IDX_W+1)'(KEY_END)) nxt_raw = (IDX_W+1)'(IV_POS);
    nxt_c     = (nxt_raw > {1'b0, cap_cur}) ? {1'b0, cap_cur} : nxt_raw;
    wr0_en    = acc && (nb != 2'd0) && (wp < cap_cur);
    wr0_idx   = wp;
    wr1_en    = acc && (nb == 2'd2) && (({1'b0, wp} + 1'b1) < {1'b0, cap_cur});
    wr1_idx   = wp + 1'b1;
    hdr_en    = acc && !seg_open && mac_key;
    clr       = out_valid && out_ready;
    dpx       = !is_spg(md);
    frm       = frm_q;
    x0_en = 1'b0; x0_idx = '0; x0_val = '0;
    x1_en = 1'b0; x1_idx = '0; x1_val = '0;
    if (st == ST_PAD) begin
      case (md)
        MD_HASH, MD_MAC: begin
          x0_en = 1'b1; x0_idx = ptr;                   x0_val = PAD_OPEN;
          x1_en = 1'b1; x1_idx = IDX_W'(SPG_BYTES - 1); x1_val = PAD_CLOSE;
        end
        MD_PRNG: begin
          x0_en = 1'b1; x0_idx = IDX_W'(SEED_BYTES);
          x0_val = seq_end ? PRNG_END : PRNG_MID;
        end
        default: ;
      endcase
    end
  end

  logic [FRM_W-1:0] frm_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= ST_FILL; md <= MD_HASH; kd <= KD_MSG;
      seg_open <= 1'b0; last_seen <= 1'b0; pad_pend <= 1'b0; seq_end <= 1'b0;
      ptr <= '0; frm_q <= '0;
    end else begin
      case (st)
        ST_FILL: if (acc) begin
          seg_open <= 1'b1;
          md       <= cur_md;
          kd       <= cur_kd;
          ptr      <= nxt_c[IDX_W-1:0];
          if (in_last) begin
            last_seen <= 1'b1;
            seq_end   <= in_seq_end;
            if (is_spg(cur_md) && nxt_c == {1'b0, cap_cur}) begin
              st <= ST_SEND; pad_pend <= 1'b1; frm_q <= '0;
            end else begin
              st <= ST_PAD;
            end
          end else if (cur_md != MD_PRNG && nxt_c == {1'b0, cap_cur}) begin
            st    <= ST_SEND;
            frm_q <= (cur_md == MD_AEAD && cur_kd != KD_AD) ? FRM_MSG_MID : FRM_AD_MID;
          end
        end
        ST_PAD: begin
          st <= ST_SEND;
          case (md)
            MD_AEAD: frm_q <= FRM_END;
            MD_PRNG: frm_q <= PRNG_TAIL;
            default: frm_q <= '0;
          endcase
        end
        ST_SEND: if (out_ready) begin
          ptr   <= '0;
          frm_q <= '0;
          if (pad_pend) begin
            pad_pend <= 1'b0;
            st       <= ST_PAD;
          end else begin
            st <= ST_FILL;
            if (last_seen) begin
              seg_open  <= 1'b0;
              last_seen <= 1'b0;
            end
          end
        end
        default: st <= ST_FILL;
      endcase
    end
  end

  // R2: padding takes exactly one cycle before the block is offered
  assert_pad_one_cycle_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_PAD) |=> (st == ST_SEND));
  // R1: the fill pointer never passes the block capacity of the mode in use
  assert_ptr_cap_R1: assert property (@(posedge clk) disable iff (!rst_n)
    ptr <= cap_of(md));
  // R8: every PRNG block leaves with the 0x08 tail nibble
  assert_prng_tail_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_SEND && md == MD_PRNG) |-> (frm_q == PRNG_TAIL));
  // R7: a block sent before the segment end never carries the last frame
  assert_aead_mid_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_SEND && md == MD_AEAD && !last_seen) |-> (frm_q != FRM_END));
endmodule

// File: rtl/spdx_store.sv
module spdx_store
  import spdx_pkg::*;
#(
  parameter int DEPTH = DPX_BYTES,
  localparam int IW = $clog2(DEPTH + 1)
)(
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  clr,
  input  logic                  wr0_en,
  input  logic [IW-1:0]         wr0_idx,
  input  logic [7:0]            wr0_dat,
  input  logic                  wr1_en,
  input  logic [IW-1:0]         wr1_idx,
  input  logic [7:0]            wr1_dat,
  input  logic                  hdr_en,
  input  logic                  x0_en,
  input  logic [IW-1:0]         x0_idx,
  input  logic [7:0]            x0_val,
  input  logic                  x1_en,
  input  logic [IW-1:0]         x1_idx,
  input  logic [7:0]            x1_val,
  output logic [DEPTH-1:0][7:0] mem
);
  for (genvar g = 0; g < DEPTH; g++) begin : g_byte
    localparam bit         HSEL = (g == 0) || (g == KEY_END) || (g == LEN_POS);
    localparam logic [7:0] HVAL = (g == 0) ? KEY_TAG : (g == KEY_END) ? KEY_SEP : LEN_HI;
    logic [7:0] q, nv;

    always_comb begin
      nv = q;
      if (wr0_en && wr0_idx == IW'(g)) nv = wr0_dat;
      if (wr1_en && wr1_idx == IW'(g)) nv = wr1_dat;
      if (hdr_en && HSEL) nv = HVAL;
      if (x0_en && x0_idx == IW'(g)) nv = nv ^ x0_val;
      if (x1_en && x1_idx == IW'(g)) nv = nv ^ x1_val;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)   q <= '0;
      else if (clr) q <= '0;
      else          q <= nv;
    end

    assign mem[g] = q;
  end

  // R4: a delivered block leaves an all-zero buffer for the next one
  assert_clear_R4: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (mem == '0));
endmodule

// File: rtl/spdx_format.sv
module spdx_format
  import spdx_pkg::*;
#(
  parameter int DEPTH = DPX_BYTES,
  parameter int SPG   = SPG_BYTES,
  localparam int OW   = DEPTH * 8 + FRM_W
)(
  input  logic [DEPTH-1:0][7:0] mem,
  input  logic [FRM_W-1:0]      frm,
  input  logic                  dpx,
  output logic [OW-1:0]         blk
);
  logic [OW-1:0] dpx_v, spg_v;

  for (genvar g = 0; g < DEPTH; g++) begin : g_map
    assign dpx_v[OW-1-8*g -: 8] = mem[g];
    if (g < SPG) begin : g_spg
      assign spg_v[SPG*8-1-8*g -: 8] = mem[g];
    end
  end
  assign dpx_v[FRM_W-1:0]  = frm;
  assign spg_v[OW-1:SPG*8] = '0;

  assign blk = dpx ? dpx_v : spg_v;
endmodule

// File: rtl/spdx_padder.sv
module spdx_padder
  import spdx_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  output logic             in_ready,
  input  logic [15:0]      in_data,
  input  logic [1:0]       in_bytes,
  input  logic             in_last,
  input  logic             in_seq_end,
  input  logic [1:0]       mode,
  input  logic [1:0]       kind,
  output logic             out_valid,
  input  logic             out_ready,
  output logic [OUT_W-1:0] out_block
);
  logic             clr, wr0_en, wr1_en, hdr_en, x0_en, x1_en, dpx;
  logic [IDX_W-1:0] wr0_idx, wr1_idx, x0_idx, x1_idx;
  logic [7:0]       x0_val, x1_val;
  logic [FRM_W-1:0] frm;
  logic [DPX_BYTES-1:0][7:0] mem;

  spdx_ctrl i_ctrl (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_bytes(in_bytes),
    .in_last(in_last), .in_seq_end(in_seq_end), .mode_i(mode), .kind_i(kind),
    .in_ready(in_ready), .out_valid(out_valid), .out_ready(out_ready),
    .clr(clr), .wr0_en(wr0_en), .wr0_idx(wr0_idx), .wr1_en(wr1_en), .wr1_idx(wr1_idx),
    .hdr_en(hdr_en), .x0_en(x0_en), .x0_idx(x0_idx), .x0_val(x0_val),
    .x1_en(x1_en), .x1_idx(x1_idx), .x1_val(x1_val), .dpx(dpx), .frm(frm)
  );

  spdx_store #(.DEPTH(DPX_BYTES)) i_store (
    .clk(clk), .rst_n(rst_n), .clr(clr),
    .wr0_en(wr0_en), .wr0_idx(wr0_idx), .wr0_dat(in_data[15:8]),
    .wr1_en(wr1_en), .wr1_idx(wr1_idx), .wr1_dat(in_data[7:0]),
    .hdr_en(hdr_en), .x0_en(x0_en), .x0_idx(x0_idx), .x0_val(x0_val),
    .x1_en(x1_en), .x1_idx(x1_idx), .x1_val(x1_val), .mem(mem)
  );

  spdx_format #(.DEPTH(DPX_BYTES), .SPG(SPG_BYTES)) i_format (
    .mem(mem), .frm(frm), .dpx(dpx), .blk(out_block)
  );

  // R9: an offered block holds until it is taken
  assert_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_block)));
  // R9: a taken block is withdrawn in the next cycle
  assert_drop_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_ready) |=> !out_valid);
endmodule

// File: tb/test_spdx_padder.sv
module test_spdx_padder;
  localparam int CLK_PERIOD = 10;
  localparam int OW = 1348;

  typedef logic [7:0] bq_t[$];

  logic clk = 1'b0, rst_n = 1'b0;
  logic in_valid = 1'b0, in_last = 1'b0, in_seq_end = 1'b0, out_ready = 1'b1;
  logic [15:0] in_data = '0;
  logic [1:0] in_bytes = '0, mode = '0, kind = '0;
  logic in_ready, out_valid;
  logic [OW-1:0] out_block;

  int checks = 0, errors = 0, cyc = 0;
  bit running = 1'b0, stall = 1'b0;
  logic [15:0] lfsr = 16'hACE1;
  logic [OW-1:0] exp_q[$];
  string tag_q[$];
  logic prev_v = 1'b0, prev_r = 1'b0;
  logic [OW-1:0] prev_blk = '0;

  always #(CLK_PERIOD/2) clk = ~clk;

  spdx_padder i_spdx_padder (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_data(in_data), .in_bytes(in_bytes), .in_last(in_last), .in_seq_end(in_seq_end),
    .mode(mode), .kind(kind), .out_valid(out_valid), .out_ready(out_ready),
    .out_block(out_block)
  );

  function automatic logic [OW-1:0] mk(bit dpx, bq_t a, int off, logic [3:0] f);
    logic [OW-1:0] v = '0;
    if (dpx) begin
      for (int i = 0; i < 168; i++) v[OW-1-8*i -: 8] = a[off+i];
      v[3:0] = f;
    end else begin
      for (int i = 0; i < 136; i++) v[1087-8*i -: 8] = a[off+i];
    end
    return v;
  endfunction

  function automatic bq_t mkdata(int n, int s);
    bq_t d;
    for (int i = 0; i < n; i++) d.push_back(8'((i * 7 + s) & 8'hFF));
    return d;
  endfunction

  task automatic push_spg(bq_t d, string tag);
    bq_t a;
    int n = d.size() / 136 + 1;
    for (int i = 0; i < n * 136; i++) a.push_back(i < d.size() ? d[i] : 8'h00);
    a[d.size()] = a[d.size()] ^ 8'h01;
    a[n*136-1] = a[n*136-1] ^ 8'h80;
    for (int k = 0; k < n; k++) begin
      exp_q.push_back(mk(1'b0, a, k * 136, 4'h0));
      tag_q.push_back(tag);
    end
  endtask

  task automatic push_aead(bit is_ad, bq_t d, string tag);
    bq_t a;
    int n = (d.size() == 0) ? 1 : (d.size() + 167) / 168;
    for (int i = 0; i < n * 168; i++) a.push_back(i < d.size() ? d[i] : 8'h00);
    for (int k = 0; k < n; k++) begin
      exp_q.push_back(mk(1'b1, a, k * 168, (k == n - 1) ? 4'h1 : (is_ad ? 4'h0 : 4'h3)));
      tag_q.push_back(tag);
    end
  endtask

  task automatic push_prng(bq_t d, bit fin, string tag);
    bq_t a;
    for (int i = 0; i < 168; i++) a.push_back((i < 32 && i < d.size()) ? d[i] : 8'h00);
    a[32] = fin ? 8'h06 : 8'h05;
    exp_q.push_back(mk(1'b1, a, 0, 4'h8));
    tag_q.push_back(tag);
  endtask

  task automatic send_seg(logic [1:0] md, logic [1:0] kd, bit se, bq_t d);
    int n = d.size();
    int nw = (n == 0) ? 1 : (n + 1) / 2;
    for (int w = 0; w < nw; w++) begin
      @(negedge clk);
      mode = md; kind = kd; in_valid = 1'b1;
      in_last = (w == nw - 1);
      in_seq_end = se;
      in_bytes = (n - 2*w >= 2) ? 2'd2 : 2'(n - 2*w);
      in_data[15:8] = (2*w < n) ? d[2*w] : 8'h5A;
      in_data[7:0]  = (2*w + 1 < n) ? d[2*w+1] : 8'hA5;
      while (!in_ready) @(negedge clk);
      @(posedge clk);
    end
    @(negedge clk);
    in_valid = 1'b0; in_last = 1'b0;
  endtask

  // per-cycle comparison against the expected block queue
  always @(negedge clk) begin
    cyc++;
    lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
    out_ready = stall ? lfsr[0] : 1'b1;
    if (running) begin
      if (prev_v && !prev_r) begin
        checks++;
        if (!(out_valid && out_block == prev_blk)) begin
          errors++;
          $display("FAIL R9 held block changed: valid=%0b exp valid=1", out_valid);
        end
      end
      if (out_valid) begin
        checks++;
        if (in_ready) begin
          errors++;
          $display("FAIL R9 in_ready=%0b while block pending, expected 0", in_ready);
        end
      end
      if (out_valid && out_ready) begin
        checks++;
        if (exp_q.size() == 0) begin
          errors++;
          $display("FAIL R9 unexpected block got %h expected none", out_block);
        end else begin
          if (out_block !== exp_q[0]) begin
            errors++;
            $display("FAIL %s block got %h expected %h", tag_q[0], out_block, exp_q[0]);
          end
          void'(exp_q.pop_front());
          void'(tag_q.pop_front());
        end
      end
    end
    prev_v = out_valid; prev_r = out_ready; prev_blk = out_block;
    if (cyc > 100000) begin
      errors++;
      $display("FAIL watchdog expired at cycle %0d, expected completion", cyc);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    bq_t key, iv, kp;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    checks += 2;
    if (out_valid !== 1'b0) begin errors++; $display("FAIL R10 out_valid=%0b expected 0", out_valid); end
    if (in_ready !== 1'b1) begin errors++; $display("FAIL R10 in_ready=%0b expected 1", in_ready); end
    running = 1'b1;

    // R1/R2: odd-length hash tail
    push_spg(mkdata(5, 3), "R2"); send_seg(2'd0, 2'd2, 1'b0, mkdata(5, 3));
    // R5: empty message
    push_spg(mkdata(0, 0), "R5"); send_seg(2'd0, 2'd2, 1'b0, mkdata(0, 0));
    // R3: merged 0x81 byte
    push_spg(mkdata(135, 9), "R3"); send_seg(2'd0, 2'd2, 1'b0, mkdata(135, 9));
    // R4: exact fill gives a padding-only block
    push_spg(mkdata(136, 1), "R4"); send_seg(2'd1, 2'd2, 1'b0, mkdata(136, 1));
    // R1: multi-block hash
    push_spg(mkdata(300, 11), "R1"); send_seg(2'd0, 2'd2, 1'b0, mkdata(300, 11));
    // R6: MAC key/IV block then a MAC message
    key = mkdata(16, 40); iv = mkdata(16, 90);
    kp.push_back(8'h1E);
    foreach (key[i]) kp.push_back(key[i]);
    kp.push_back(8'h01);
    for (int i = 0; i < 12; i++) kp.push_back(8'h00);
    kp.push_back(8'h01); kp.push_back(8'h00);
    foreach (iv[i]) kp.push_back(iv[i]);
    push_spg(kp, "R6"); send_seg(2'd1, 2'd0, 1'b0, {key, iv});
    push_spg(mkdata(20, 77), "R6"); send_seg(2'd1, 2'd2, 1'b0, mkdata(20, 77));

    stall = 1'b1;
    // R7: AEAD frames
    push_aead(1'b1, mkdata(40, 5), "R7"); send_seg(2'd2, 2'd1, 1'b0, mkdata(40, 5));
    push_aead(1'b0, mkdata(200, 6), "R7"); send_seg(2'd2, 2'd2, 1'b0, mkdata(200, 6));
    push_aead(1'b1, mkdata(168, 8), "R7"); send_seg(2'd2, 2'd1, 1'b0, mkdata(168, 8));
    // R8: PRNG seed, empty seed at sequence end, long seed truncated
    push_prng(mkdata(32, 13), 1'b0, "R8"); send_seg(2'd3, 2'd3, 1'b0, mkdata(32, 13));
    push_prng(mkdata(0, 0), 1'b1, "R8"); send_seg(2'd3, 2'd3, 1'b1, mkdata(0, 0));
    push_prng(mkdata(40, 21), 1'b1, "R8"); send_seg(2'd3, 2'd3, 1'b1, mkdata(40, 21));
    // R9: hash under back-pressure
    push_spg(mkdata(272, 2), "R9"); send_seg(2'd0, 2'd2, 1'b0, mkdata(272, 2));

    for (int i = 0; i < 3000 && (exp_q.size() != 0 || out_valid); i++) @(negedge clk);
    checks++;
    if (exp_q.size() != 0) begin
      errors++;
      $display("FAIL R9 blocks outstanding got %0d expected 0", exp_q.size());
    end
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule